// File: doc/BRIEF.md
# Runt-free clock stop gating

This block switches a bank of clock outputs on and off in response to two active-low halt requests, and never cuts a pulse short. The core halt request parks the gated core-clock copies and the gated memory-clock copies. The bus halt request parks the gated bus-clock copies. One free copy of each source clock ignores both requests. A per-output enable vector, taken from a configuration register, can hold any single output LOW.

The block is logic on a fast sampling clock `clk` that observes the three source clocks as plain level inputs. Each domain has its own lane: a request synchronizer clocked by the source's rising edges, a four-state gate controller, and an enable capture register. The gate controller has four states. GS_RUN passes pulses. GS_DRAIN lets the current pulse finish. GS_PARK holds the outputs LOW. GS_WAKE waits for a low phase before passing pulses again.

The transitions are:
- RUN to DRAIN when the synchronized request goes LOW.
- DRAIN to PARK when the source is LOW.
- DRAIN back to RUN if the request is withdrawn.
- PARK to WAKE when the request is released.
- WAKE to RUN when the source is LOW.
- WAKE back to PARK if the request returns.

Because of these rules the gate, and the captured enables, only change while the source is LOW.

Top module: `clkstop_gater`

## Requirements
- R1: While `rst_n` is LOW every output is LOW. After reset, with all enable bits 1 and both halt inputs HIGH, every output copies its source clock.
- R2: The core halt is sampled at each rising edge of a domain's source and passes two such samples. After it goes LOW, the pulses that begin at the first and second rising edges are complete. From the third rising edge on, `core_o` and `mem_o` stay LOW, each counted against its own source.
- R3: After the core halt returns HIGH, gated core and memory pulses resume at the third rising edge of their source, with a full-width high phase.
- R4: A gated output rises only at a rising edge of its source and falls only at a falling edge of its source, so no runt pulse is produced.
- R5: The bus halt is sampled at a rising edge of the bus source. The bus pulse that begins at the next rising edge, and all later ones while the halt stays LOW, are suppressed on `bus_o`.
- R6: After the bus halt is sampled HIGH, `bus_o` pulses resume at the next rising edge of the bus source.
- R7: `core_free_o`, `mem_free_o` and `bus_free_o` follow their sources whatever the halt inputs do.
- R8: `out_en` layout with default sizes: bit 0 is the core free copy, bits 3:1 are `core_o[2:0]`, bit 4 is the memory free copy, bits 16:5 are `mem_o[11:0]`, bit 17 is the bus free copy, and bits 22:18 are `bus_o[4:0]`. An output whose bit is 0 stays LOW regardless of the halts.
- R9: An enable change is captured only while that output's source is LOW. It takes effect from the next high phase of that source and never shortens a pulse in progress.
- R10: A halt that is LOW at exactly one sampling rising edge removes exactly one pulse from the affected gated outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_clk_i | input | 1 | Core source clock, as a level sampled by `clk` |
| mem_clk_i | input | 1 | Memory source clock, as a level |
| bus_clk_i | input | 1 | Bus source clock, as a level |
| core_halt_n | input | 1 | Active-low halt for gated core and memory copies |
| bus_halt_n | input | 1 | Active-low halt for gated bus copies |
| out_en | input | 23 | Per-output enable, with the layout in R8 |
| core_free_o | output | 1 | Free core copy |
| core_o | output | 3 | Gated core copies |
| mem_free_o | output | 1 | Free memory copy |
| mem_o | output | 12 | Gated memory copies |
| bus_free_o | output | 1 | Free bus copy |
| bus_o | output | 5 | Gated bus copies |

## Verification
The assertions take four things for granted:
- Each source clock is a clean square wave that is synchronous to `clk`.
- Each high phase and each low phase lasts at least two `clk` cycles, so a single rising edge is seen once and the gate always gets a LOW sample in which to move.
- The halt inputs change synchronously to `clk`.
- The enable vector changes synchronously to `clk`.

The stimulus derives all three sources from one phase counter, with four samples HIGH and four LOW, at different offsets. It changes halts and enables at a single fixed point in the counter cycle, so every expected pulse lands on a known source period.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Gate controller states shared by every lane
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_DRAIN = 2'd1,
        GS_PARK  = 2'd2,
        GS_WAKE  = 2'd3
    } gate_state_t;

endpackage

// File: rtl/clkstop_edge_sync.sv
module clkstop_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic req_n_i,
    output logic go_o
);

    logic              src_q;
    logic              rise;
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= 1'b0;
        end else begin
            src_q <= src_i;
        end
    end

    assign rise = src_i & ~src_q;

    // Each stage advances only at a rising edge of the source domain
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shift_q <= '1;
                end else if (rise) begin
                    shift_q <= req_n_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shift_q <= '1;
                end else if (rise) begin
                    shift_q <= {shift_q[STAGES-2:0], req_n_i};
                end
            end
        end
    endgenerate

    assign go_o = shift_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate_fsm.sv
module clkstop_gate_fsm
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic go_i,
    output logic gate_o
);

    gate_state_t state_q;
    gate_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Opening and closing are deferred to a LOW phase of the source
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:   if (!go_i) state_d = GS_DRAIN;
            GS_DRAIN: begin
                if (go_i)        state_d = GS_RUN;
                else if (!src_i) state_d = GS_PARK;
            end
            GS_PARK:  if (go_i) state_d = GS_WAKE;
            GS_WAKE:  begin
                if (!go_i)       state_d = GS_PARK;
                else if (!src_i) state_d = GS_RUN;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            GS_RUN, GS_DRAIN: gate_o = 1'b1;
            GS_PARK, GS_WAKE: gate_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane #(
    parameter int N_GATED = 3,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_i,
    input  logic               req_n_i,
    input  logic [N_GATED:0]   en_i,
    output logic               free_o,
    output logic [N_GATED-1:0] gated_o
);

    logic             go;
    logic             gate;
    logic [N_GATED:0] en_q;

    clkstop_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .req_n_i (req_n_i),
        .go_o    (go)
    );

    clkstop_gate_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .go_i   (go),
        .gate_o (gate)
    );

    // Enables move only in a LOW phase so they cannot truncate a pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (!src_i) begin
            en_q <= en_i;
        end
    end

    assign free_o = src_i & en_q[0];

    generate
        for (genvar i = 0; i < N_GATED; i++) begin : g_out
            assign gated_o[i] = src_i & gate & en_q[i+1];
        end
    endgenerate

endmodule

// File: rtl/clkstop_gater.sv
module clkstop_gater #(
    parameter int N_CORE    = 3,
    parameter int N_MEM     = 12,
    parameter int N_BUS     = 5,
    parameter int CORE_SYNC = 2,
    parameter int BUS_SYNC  = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            core_clk_i,
    input  logic                            mem_clk_i,
    input  logic                            bus_clk_i,
    input  logic                            core_halt_n,
    input  logic                            bus_halt_n,
    input  logic [N_CORE+N_MEM+N_BUS+2:0]   out_en,
    output logic                            core_free_o,
    output logic [N_CORE-1:0]               core_o,
    output logic                            mem_free_o,
    output logic [N_MEM-1:0]                mem_o,
    output logic                            bus_free_o,
    output logic [N_BUS-1:0]                bus_o
);

    localparam int CORE_BASE = 0;
    localparam int MEM_BASE  = N_CORE + 1;
    localparam int BUS_BASE  = N_CORE + N_MEM + 2;

    clkstop_lane #(.N_GATED(N_CORE), .STAGES(CORE_SYNC)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (core_clk_i),
        .req_n_i (core_halt_n),
        .en_i    (out_en[CORE_BASE +: N_CORE+1]),
        .free_o  (core_free_o),
        .gated_o (core_o)
    );

    // Memory copies obey the core halt but are timed by their own source
    clkstop_lane #(.N_GATED(N_MEM), .STAGES(CORE_SYNC)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (mem_clk_i),
        .req_n_i (core_halt_n),
        .en_i    (out_en[MEM_BASE +: N_MEM+1]),
        .free_o  (mem_free_o),
        .gated_o (mem_o)
    );

    clkstop_lane #(.N_GATED(N_BUS), .STAGES(BUS_SYNC)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (bus_clk_i),
        .req_n_i (bus_halt_n),
        .en_i    (out_en[BUS_BASE +: N_BUS+1]),
        .free_o  (bus_free_o),
        .gated_o (bus_o)
    );

endmodule

// File: rtl/clkstop_gater_chk.sv
module clkstop_gater_chk #(
    parameter int N_CORE    = 3,
    parameter int N_MEM     = 12,
    parameter int N_BUS     = 5,
    parameter int CORE_SYNC = 2,
    parameter int BUS_SYNC  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_clk_i,
    input logic              mem_clk_i,
    input logic              bus_clk_i,
    input logic              core_halt_n,
    input logic              bus_halt_n,
    input logic [N_CORE-1:0] core_o,
    input logic [N_MEM-1:0]  mem_o,
    input logic [N_BUS-1:0]  bus_o
);

    logic       core_d, mem_d, bus_d;
    logic [3:0] core_cnt, mem_cnt, bus_cnt;

    // Count source rising edges seen while a halt has stayed LOW
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_d   <= 1'b0;
            mem_d    <= 1'b0;
            bus_d    <= 1'b0;
            core_cnt <= '0;
            mem_cnt  <= '0;
            bus_cnt  <= '0;
        end else begin
            core_d <= core_clk_i;
            mem_d  <= mem_clk_i;
            bus_d  <= bus_clk_i;
            if (core_halt_n) core_cnt <= '0;
            else if (core_clk_i && !core_d && core_cnt != 4'hF) core_cnt <= core_cnt + 4'd1;
            if (core_halt_n) mem_cnt <= '0;
            else if (mem_clk_i && !mem_d && mem_cnt != 4'hF) mem_cnt <= mem_cnt + 4'd1;
            if (bus_halt_n) bus_cnt <= '0;
            else if (bus_clk_i && !bus_d && bus_cnt != 4'hF) bus_cnt <= bus_cnt + 4'd1;
        end
    end

    a_r2_core_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cnt >= 4'(CORE_SYNC + 1) && core_clk_i) |-> (core_o == '0));

    a_r2_mem_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cnt >= 4'(CORE_SYNC + 1) && mem_clk_i) |-> (mem_o == '0));

    a_r5_bus_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cnt >= 4'(BUS_SYNC + 1) && bus_clk_i) |-> (bus_o == '0));

    a_r4_core_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(core_o) & ~core_o)) |-> !core_clk_i);

    a_r4_core_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(core_o) & core_o)) |-> (core_clk_i && !$past(core_clk_i)));

    a_r4_mem_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(mem_o) & ~mem_o)) |-> !mem_clk_i);

    a_r4_bus_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(bus_o) & ~bus_o)) |-> !bus_clk_i);

    a_r4_bus_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(bus_o) & bus_o)) |-> (bus_clk_i && !$past(bus_clk_i)));

endmodule

bind clkstop_gater clkstop_gater_chk #(
    .N_CORE(N_CORE), .N_MEM(N_MEM), .N_BUS(N_BUS),
    .CORE_SYNC(CORE_SYNC), .BUS_SYNC(BUS_SYNC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_clk_i  (core_clk_i),
    .mem_clk_i   (mem_clk_i),
    .bus_clk_i   (bus_clk_i),
    .core_halt_n (core_halt_n),
    .bus_halt_n  (bus_halt_n),
    .core_o      (core_o),
    .mem_o       (mem_o),
    .bus_o       (bus_o)
);

// File: tb/sim_clkstop_gater.sv
module sim_clkstop_gater;

    localparam int NC   = 3;
    localparam int NM   = 12;
    localparam int NB   = 5;
    localparam int EW   = NC + NM + NB + 3;
    localparam int MB   = NC + 1;
    localparam int BB   = NC + NM + 2;
    localparam int NPER = 44;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [2:0]    cnt = 3'd0;
    int            per = -1;
    logic          core_halt_n = 1'b1;
    logic          bus_halt_n = 1'b1;
    logic [EW-1:0] out_en = '1;

    logic          core_clk_i, mem_clk_i, bus_clk_i;
    logic          core_free_o, mem_free_o, bus_free_o;
    logic [NC-1:0] core_o;
    logic [NM-1:0] mem_o;
    logic [NB-1:0] bus_o;

    // Sources: core high at phases 0-3, memory 2-5, bus 4-7
    assign core_clk_i = (cnt < 3'd4);
    assign mem_clk_i  = (cnt >= 3'd2) && (cnt <= 3'd5);
    assign bus_clk_i  = (cnt >= 3'd4);

    clkstop_gater u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_clk_i  (core_clk_i),
        .mem_clk_i   (mem_clk_i),
        .bus_clk_i   (bus_clk_i),
        .core_halt_n (core_halt_n),
        .bus_halt_n  (bus_halt_n),
        .out_en      (out_en),
        .core_free_o (core_free_o),
        .core_o      (core_o),
        .mem_free_o  (mem_free_o),
        .mem_o       (mem_o),
        .bus_free_o  (bus_free_o),
        .bus_o       (bus_o)
    );

    typedef struct {
        int          tgt;
        logic [15:0] val;
        string       req;
    } item_t;

    item_t q_core[$];
    item_t q_mem[$];
    item_t q_bus[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit hist_core[0:63];
    bit hist_bus[0:63];
    logic [EW-1:0] hist_en[0:63];

    function automatic bit core_plan(int k);
        return !((k >= 4 && k <= 9) || (k >= 24 && k <= 27) || k == 32);
    endfunction

    function automatic bit bus_plan(int k);
        return !((k >= 14 && k <= 17) || (k >= 24 && k <= 27) || k == 36);
    endfunction

    function automatic logic [EW-1:0] en_plan(int k);
        logic [EW-1:0] p;
        for (int i = 0; i < EW; i++) p[i] = i[0];
        if (k >= 20 && k <= 23) return p;
        if (k >= 24 && k <= 29) return ~p;
        if (k >= 38 && k <= 39) return '0;
        return '1;
    endfunction

    function automatic bit core_gate(int t);
        return (t - 3 < 0) ? 1'b1 : hist_core[t-3];
    endfunction

    function automatic bit bus_gate(int t);
        return (t - 2 < 0) ? 1'b1 : hist_bus[t-2];
    endfunction

    // Driver: applies one period's stimulus and pushes what the next period must show
    task automatic drive_period(int k);
        logic [EW-1:0] e;
        bit            g, gp, b, bp;
        int            t;
        item_t         it;
        string         tag;
        e = en_plan(k);
        hist_core[k] = core_plan(k);
        hist_bus[k]  = bus_plan(k);
        hist_en[k]   = e;
        core_halt_n <= hist_core[k];
        bus_halt_n  <= hist_bus[k];
        out_en      <= e;
        t  = k + 1;
        g  = core_gate(t);
        gp = core_gate(t - 1);
        b  = bus_gate(t);
        bp = bus_gate(t - 1);
        tag = !g ? "R2 R7" : (!gp ? "R3" : "R1");
        if (t - 3 == 32 || t - 3 == 31) tag = {tag, " R10"};
        if (e != '1) tag = {tag, " R8"};
        if (k > 0 && e != hist_en[k-1]) tag = {tag, " R9"};
        it.tgt = t;
        it.req = tag;
        it.val = '0;
        it.val[NC:0] = {e[NC:1] & {NC{g}}, e[0]};
        q_core.push_back(it);
        it.val = '0;
        it.val[NM:0] = {e[MB+NM:MB+1] & {NM{g}}, e[MB]};
        q_mem.push_back(it);
        tag = !b ? "R5 R7" : (!bp ? "R6" : "R1");
        if (t - 2 == 36) tag = {tag, " R10"};
        if (e != '1) tag = {tag, " R8"};
        if (k > 0 && e != hist_en[k-1]) tag = {tag, " R9"};
        it.req = tag;
        it.val = '0;
        it.val[NB:0] = {e[BB+NB:BB+1] & {NB{b}}, e[BB]};
        q_bus.push_back(it);
    endtask

    task automatic compare(string dom, string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s period %0d: actual %h expected %h", req, dom, per, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Phase counter and stimulus driver
    initial begin
        forever begin
            @(posedge clk);
            if (cnt == 3'd5 && per >= 0 && per < NPER) drive_period(per);
            if (cnt == 3'd7) per <= per + 1;
            cnt <= cnt + 3'd1;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
    end

    // Monitor: pops expected items at the first and last sample of each high phase
    initial begin
        logic [15:0] a;
        @(negedge clk);
        a = '0;
        a[NC:0] = {core_o, core_free_o};
        compare("reset core", "R1", a, 16'h0);
        a = '0;
        a[NM:0] = {mem_o, mem_free_o};
        compare("reset mem", "R1", a, 16'h0);
        a = '0;
        a[NB:0] = {bus_o, bus_free_o};
        compare("reset bus", "R1", a, 16'h0);
        forever begin
            @(negedge clk);
            if ((cnt == 3'd0 || cnt == 3'd3) && q_core.size() > 0 && q_core[0].tgt == per) begin
                a = '0;
                a[NC:0] = {core_o, core_free_o};
                compare("core", (cnt == 3'd3) ? {q_core[0].req, " R4"} : q_core[0].req, a, q_core[0].val);
                if (cnt == 3'd3) void'(q_core.pop_front());
            end
            if ((cnt == 3'd2 || cnt == 3'd5) && q_mem.size() > 0 && q_mem[0].tgt == per) begin
                a = '0;
                a[NM:0] = {mem_o, mem_free_o};
                compare("mem", (cnt == 3'd5) ? {q_mem[0].req, " R4"} : q_mem[0].req, a, q_mem[0].val);
                if (cnt == 3'd5) void'(q_mem.pop_front());
            end
            if ((cnt == 3'd4 || cnt == 3'd7) && q_bus.size() > 0 && q_bus[0].tgt == per) begin
                a = '0;
                a[NB:0] = {bus_o, bus_free_o};
                compare("bus", (cnt == 3'd7) ? {q_bus[0].req, " R4"} : q_bus[0].req, a, q_bus[0].val);
                if (cnt == 3'd7) void'(q_bus.pop_front());
            end
            if (per >= NPER + 2 && q_core.size() == 0 && q_mem.size() == 0 && q_bus.size() == 0)
                finish_run();
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule